// File: doc/BRIEF.md
# Nine-Level Ladder Staircase Sequencer

This block drives the eight gates of a ladder-type multilevel inverter built from four equal DC sources feeding an H-bridge. It produces a fundamental-frequency staircase: within each half-cycle the output magnitude climbs from zero to four source voltages and back down again. A table of four tick counts sets the switching instants, and the staircase is quarter-wave symmetric. The first half-cycle is positive and the next is negative, and the pattern repeats for as long as the enable input is high.

Each level selects one ladder switch plus an H-bridge pair. The polarity of the level decides which pair is used. At the zero level no ladder switch conducts, and the bridge shorts the load through either its upper pair or its lower pair. The two choices alternate from one zero interval to the next, so that the conduction stress is shared. Gate and level outputs are registered. Dead-time insertion and any modulation finer than the staircase belong to downstream logic.

The control FSM has three states. SEQ_OFF is entered on reset or whenever enable is low, and all gates are off in it. SEQ_POS is the positive half-cycle and SEQ_NEG is the negative one. Its transitions are:
- start: SEQ_OFF to SEQ_POS when enable is seen high.
- flip: SEQ_POS to SEQ_NEG, and SEQ_NEG to SEQ_POS, when the half-cycle counter reaches 2Q-1.
- halt: any state to SEQ_OFF when enable is seen low.

Top module: `ladder_stair_seq`

## Requirements
- R1: `level_o` is a signed two's-complement value in the range -4 to +4. Let Q be QUARTER_TICKS and let t be the phase within the current half-cycle, where 0 <= t < 2Q. The magnitude equals the number of table angles a with a <= t < 2Q - a. The sign is positive in the first half-cycle after start and alternates every 2Q clocks after that.
- R2: A positive level k turns on exactly ladder switch k (`gate_o` bit k-1) plus H1 (bit 4) and H2 (bit 5).
- R3: A negative level -k turns on exactly ladder switch k (bit k-1) plus H3 (bit 6) and H4 (bit 7).
- R4: While enabled, a zero level turns on no ladder switch and only one of two bridge pairs: H1+H3 (bits 4 and 6) or H2+H4 (bits 5 and 7).
- R5: The first zero interval after reset or enable uses H1+H3. Each later zero interval uses the other pair from the one before it.
- R6: At most one ladder bit is ever set, and every nonzero level has exactly three gates on.
- R7: A clock edge that samples enable low clears all gates and the level to zero. They stay at zero while enable remains low.
- R8: Reset clears all outputs. After enable is first sampled high, the outputs stay off for one more edge. Each edge after that presents the next phase, starting from t=0 of a positive half-cycle.
- R9: Table angles that are equal make the level jump several steps in a single clock. An angle of 0 removes the zero interval, so the level passes from +1 directly to -1 at the half-cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one phase tick per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces all gates off |
| angle_tbl | input | 4*ANG_W | Switching tick counts; entry i (bits i*ANG_W upward) is where the level rises to i+1 |
| gate_o | output | 8 | Bits 3..0 ladder switches 4..1, bits 4..7 H1..H4 |
| level_o | output | 4 | Signed current output level |

## Verification
A wrong phase count or a wrong state shows at once as a level that departs from the angle-table formula. The first clock past a misplaced switching instant or half-cycle boundary exposes it, and so does a level of the wrong sign. A wrong zero-pair flag stays hidden while the level is nonzero. It appears as a swapped bridge pair at the first clock of the following zero interval, which may be up to a half-cycle later. For that reason the bench compares both the level and the full gate vector on every clock over several whole periods and for several angle tables.

// File: rtl/ladder_seq_pkg.sv
package ladder_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF = 2'd0,
        SEQ_POS = 2'd1,
        SEQ_NEG = 2'd2
    } seq_state_t;

    // offsets of the bridge gates above the ladder field
    localparam int HB_H1 = 0;
    localparam int HB_H2 = 1;
    localparam int HB_H3 = 2;
    localparam int HB_H4 = 3;
    localparam int HB_W  = 4;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import ladder_seq_pkg::*;
#(
    parameter int HALF_TICKS = 2000,
    parameter int CNT_W      = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output seq_state_t       state_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             at_end;

    assign at_end = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_OFF;
        else        state_q <= state_d;
    end

    // next state: start, flip, halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_OFF: if (en) state_d = SEQ_POS;
            SEQ_POS: begin
                if (!en)        state_d = SEQ_OFF;
                else if (at_end) state_d = SEQ_NEG;
            end
            SEQ_NEG: begin
                if (!en)        state_d = SEQ_OFF;
                else if (at_end) state_d = SEQ_POS;
            end
            default: state_d = SEQ_OFF;
        endcase
    end

    // phase counter within the half-cycle
    always_comb begin
        cnt_d = '0;
        if (en && state_q != SEQ_OFF)
            cnt_d = at_end ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/level_decoder.sv
module level_decoder #(
    parameter int N_SRC      = 4,
    parameter int ANG_W      = 12,
    parameter int CNT_W      = 11,
    parameter int HALF_TICKS = 2000,
    parameter int MAG_W      = 3
) (
    input  logic [CNT_W-1:0]       cnt_i,
    input  logic [N_SRC*ANG_W-1:0] angle_tbl,
    output logic [MAG_W-1:0]       mag_o
);

    localparam int XW = ((CNT_W > ANG_W) ? CNT_W : ANG_W) + 1;

    logic [XW-1:0]    t_x;
    logic [N_SRC-1:0] hit;

    assign t_x = XW'(cnt_i);

    // one window comparator per source: on between rise and mirrored fall
    for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
        logic [XW-1:0] a_x;
        logic [XW-1:0] lim_x;
        assign a_x    = XW'(angle_tbl[i*ANG_W +: ANG_W]);
        assign lim_x  = XW'(HALF_TICKS) - a_x;
        assign hit[i] = (t_x >= a_x) && (t_x < lim_x);
    end

    always_comb begin
        mag_o = '0;
        for (int i = 0; i < N_SRC; i++)
            mag_o = mag_o + MAG_W'(hit[i]);
    end

endmodule

// File: rtl/gate_stage.sv
module gate_stage
    import ladder_seq_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int MAG_W = 3,
    parameter int LVL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  seq_state_t              state_i,
    input  logic [MAG_W-1:0]        mag_i,
    output logic [N_SRC+HB_W-1:0]   gate_o,
    output logic signed [LVL_W-1:0] level_o
);

    localparam int GW = N_SRC + HB_W;

    logic signed [LVL_W-1:0] lvl_c, level_q;
    logic [GW-1:0]           gate_c, gate_q;
    logic                    zsel_q;
    logic                    live;

    assign live = (state_i != SEQ_OFF);

    // output decode per state
    always_comb begin
        lvl_c  = '0;
        gate_c = '0;
        unique case (state_i)
            SEQ_POS: lvl_c = $signed({1'b0, mag_i});
            SEQ_NEG: lvl_c = -$signed({1'b0, mag_i});
            default: lvl_c = '0;
        endcase
        for (int k = 0; k < N_SRC; k++)
            gate_c[k] = live && (mag_i == MAG_W'(k + 1));
        if (live) begin
            if (mag_i != '0) begin
                if (state_i == SEQ_POS) begin
                    gate_c[N_SRC + HB_H1] = 1'b1;
                    gate_c[N_SRC + HB_H2] = 1'b1;
                end else begin
                    gate_c[N_SRC + HB_H3] = 1'b1;
                    gate_c[N_SRC + HB_H4] = 1'b1;
                end
            end else if (zsel_q) begin
                gate_c[N_SRC + HB_H2] = 1'b1;
                gate_c[N_SRC + HB_H4] = 1'b1;
            end else begin
                gate_c[N_SRC + HB_H1] = 1'b1;
                gate_c[N_SRC + HB_H3] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            gate_q  <= '0;
            zsel_q  <= 1'b0;
        end else if (!en || !live) begin
            level_q <= '0;
            gate_q  <= '0;
            zsel_q  <= 1'b0;
        end else begin
            level_q <= lvl_c;
            gate_q  <= gate_c;
            // leaving a zero interval: next one uses the other pair
            if (mag_i != '0 && level_q == '0)
                zsel_q <= ~zsel_q;
        end
    end

    assign gate_o  = gate_q;
    assign level_o = level_q;

endmodule

// File: rtl/ladder_stair_seq.sv
module ladder_stair_seq
    import ladder_seq_pkg::*;
#(
    parameter int N_SRC         = 4,
    parameter int QUARTER_TICKS = 1000,
    parameter int ANG_W         = 12,
    localparam int HALF_TICKS   = 2 * QUARTER_TICKS,
    localparam int CNT_W        = $clog2(HALF_TICKS),
    localparam int MAG_W        = $clog2(N_SRC + 1),
    localparam int LVL_W        = MAG_W + 1,
    localparam int GATE_W       = N_SRC + HB_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [N_SRC*ANG_W-1:0]   angle_tbl,
    output logic [GATE_W-1:0]        gate_o,
    output logic signed [LVL_W-1:0]  level_o
);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [MAG_W-1:0] mag;

    seq_ctrl #(
        .HALF_TICKS(HALF_TICKS),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .state_o(state),
        .cnt_o  (cnt)
    );

    level_decoder #(
        .N_SRC     (N_SRC),
        .ANG_W     (ANG_W),
        .CNT_W     (CNT_W),
        .HALF_TICKS(HALF_TICKS),
        .MAG_W     (MAG_W)
    ) u_dec (
        .cnt_i    (cnt),
        .angle_tbl(angle_tbl),
        .mag_o    (mag)
    );

    gate_stage #(
        .N_SRC(N_SRC),
        .MAG_W(MAG_W),
        .LVL_W(LVL_W)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .state_i(state),
        .mag_i  (mag),
        .gate_o (gate_o),
        .level_o(level_o)
    );

endmodule

// File: rtl/ladder_seq_chk.sv
module ladder_seq_chk #(
    parameter int N_SRC = 4,
    parameter int LVL_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic [N_SRC+3:0]        gate_o,
    input logic signed [LVL_W-1:0] level_o
);

    logic [N_SRC-1:0] ladder;
    logic [3:0]       hb;
    assign ladder = gate_o[N_SRC-1:0];
    assign hb     = gate_o[N_SRC +: 4];

    // R6
    one_ladder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ladder));

    // R6
    three_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != 0) |-> ($countones(gate_o) == 3));

    // R2
    pos_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o > 0) |-> (hb == 4'b0011));

    // R3
    neg_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o < 0) |-> (hb == 4'b1100));

    // R4
    zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == 0) |-> (ladder == '0 &&
                            (hb == 4'b0101 || hb == 4'b1010 || hb == 4'b0000)));

    // R1
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o <= N_SRC) && (level_o >= -N_SRC));

    // R7
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gate_o == '0 && level_o == 0));

endmodule

bind ladder_stair_seq ladder_seq_chk #(
    .N_SRC(N_SRC),
    .LVL_W(LVL_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .gate_o (gate_o),
    .level_o(level_o)
);

// File: tb/sim_ladder_stair_seq.sv
module sim_ladder_stair_seq;

    localparam int Q     = 40;
    localparam int ANG_W = 8;
    localparam int WDOG  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [4*ANG_W-1:0] angle_tbl = '0;
    logic [7:0]        gate_o;
    logic signed [3:0] level_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    int ang [4];

    always #2 clk = ~clk;

    ladder_stair_seq #(
        .N_SRC(4),
        .QUARTER_TICKS(Q),
        .ANG_W(ANG_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .angle_tbl(angle_tbl),
        .gate_o(gate_o), .level_o(level_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            bad++;
            $display("FAIL R8 watchdog: cycles=%0d expected below %0d", cycles, WDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int exp_mag(int t);
        int m = 0;
        for (int i = 0; i < 4; i++)
            if (t >= ang[i] && t < 2*Q - ang[i]) m++;
        return m;
    endfunction

    function automatic logic [7:0] exp_gate(int lv, bit zs);
        logic [7:0] g = '0;
        if (lv > 0) begin
            g[lv-1] = 1'b1; g[4] = 1'b1; g[5] = 1'b1;
        end else if (lv < 0) begin
            g[-lv-1] = 1'b1; g[6] = 1'b1; g[7] = 1'b1;
        end else if (zs) begin
            g[5] = 1'b1; g[7] = 1'b1;
        end else begin
            g[4] = 1'b1; g[6] = 1'b1;
        end
        return g;
    endfunction

    task automatic chk_int(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic chk_off(string tag);
        chk_int({tag, " level"}, int'(level_o), 0);
        chk_int({tag, " gates"}, int'(gate_o), 0);
    endtask

    task automatic set_ang(int a0, int a1, int a2, int a3);
        ang[0] = a0; ang[1] = a1; ang[2] = a2; ang[3] = a3;
        angle_tbl = {ANG_W'(a3), ANG_W'(a2), ANG_W'(a1), ANG_W'(a0)};
    endtask

    // enable and follow the staircase for ncyc edges, checking every edge
    task automatic run_seq(int ncyc, string tag);
        int  prev = 0;
        bit  zs = 1'b0;
        @(negedge clk);
        en = 1'b1;
        for (int j = 1; j <= ncyc; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (j == 1) begin
                chk_off("R8 start delay");
            end else begin
                int p, t, m, lv;
                logic [7:0] g;
                string gt;
                p  = (j - 2) % (4*Q);
                t  = p % (2*Q);
                m  = exp_mag(t);
                lv = (p >= 2*Q) ? -m : m;
                g  = exp_gate(lv, zs);
                chk_int({tag, " level"}, int'(level_o), lv);
                gt = (lv > 0) ? "R2" : (lv < 0) ? "R3" : "R4,R5";
                chk_int({gt, " gates"}, int'(gate_o), int'(g));
                chk_int("R6 ladder count", ($countones(gate_o[3:0]) <= 1) ? 1 : 0, 1);
                if (lv != 0)
                    chk_int("R6 gates on", $countones(gate_o), 3);
                if (prev == 0 && lv != 0) zs = ~zs;
                prev = lv;
            end
        end
    endtask

    task automatic stop_seq();
        @(negedge clk);
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_off("R7 disable");
        repeat (6) @(negedge clk);
        chk_off("R7 hold off");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_off("R8 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_off("R8 idle");
    endtask

    task automatic t_basic();
        set_ang(5, 12, 20, 30);
        run_seq(2*4*Q + 10, "R1 basic");
        stop_seq();
    endtask

    task automatic t_restart();
        set_ang(3, 9, 16, 25);
        run_seq(100, "R1 partial");
        stop_seq();
        run_seq(4*Q + 20, "R8 restart");
        stop_seq();
    endtask

    task automatic t_jumps();
        set_ang(10, 10, 10, 10);
        run_seq(4*Q + 5, "R9 equal angles");
        stop_seq();
        set_ang(0, 8, 16, 24);
        run_seq(4*Q + 5, "R9 zero angle");
        stop_seq();
    endtask

    task automatic t_mid_reset();
        set_ang(6, 14, 22, 33);
        run_seq(57, "R1 pre reset");
        @(negedge clk);
        rst_n = 1'b0;
        en    = 1'b0;
        #1;
        chk_off("R8 mid reset");
        @(negedge clk);
        rst_n = 1'b1;
        run_seq(4*Q + 3, "R8 after reset");
        stop_seq();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_restart();
        t_jumps();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule